// File: doc/BRIEF.md
# Bidirectional GPIO Port with Pull-up Control

This block is an eight-bit general-purpose I/O port that sits on a simple memory-mapped register bus. It holds three registers: an output latch, a direction mask and a pull-up enable mask. For each bit it produces an output enable, an output data level and a pull-up request, which go to an external pad model. The pad's input levels come back through a two-flop synchronizer. The synchronized levels feed the port read path and a tap output that serves keyboard-interrupt logic.

Software writes the latch first and then sets direction bits to turn pins into outputs. The pin therefore leaves high impedance already carrying the intended level.

A read of the latch offset returns a mix chosen bit by bit. Output bits return the latch. Input bits return the synchronized pin.

Bus writes take effect at the clock edge on which `bus_en` and `bus_we` are both high. `bus_rdata` is a combinational function of `bus_addr` and the current state.

Top module: `gpio_port`

## Requirements
- R1: After synchronous reset, all three registers are 0x00. As a result `pin_oe`, `pin_out` and `pin_pu` are all 0x00, and every pin is an input.
- R2: The direction register at offset 0x04 and the pull-up register at offset 0x0D read back all eight bits exactly as last written.
- R3: `pin_oe` equals the direction register, where 1 means output. `pin_out` carries the latch bit for output bits and 0 for input bits. A direction write is visible on `pin_oe` one cycle after its write edge.
- R4: A read of offset 0x00 returns, for each bit, the latch bit when the direction bit is 1 and the synchronized pin bit when it is 0.
- R5: The latch at offset 0x00 accepts writes whatever the direction bits hold. While a bit is an input, such a write changes neither `pin_out`, `pin_oe` nor that bit's read value. The stored value is driven once the bit becomes an output.
- R6: `pin_pu` bit i is 1 only when pull-up bit i is 1 and direction bit i is 0. Output bits never request a pull-up.
- R7: `kbd_tap` carries the synchronized pin levels for every bit, whatever the direction setting.
- R8: A change on `pin_in` sampled at a clock edge reaches `kbd_tap`, and the input bits of a data read, after the second rising edge, not after the first.
- R9: Reads of any offset other than 0x00, 0x04 and 0x0D return 0x00. Writes to such offsets change no register.
- R10: When the latch is written before a direction bit goes from 0 to 1, `pin_out` and `pin_oe` change for that bit in the same cycle. The pin goes straight from high impedance to the new latch value. While a bit stays an output and the latch is not written, its `pin_out` holds steady.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_en | input | 1 | Bus access valid |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| pin_in | input | 8 | Levels sensed at the pads |
| pin_oe | output | 8 | Per-bit output enable to the pads |
| pin_out | output | 8 | Per-bit drive level to the pads |
| pin_pu | output | 8 | Per-bit pull-up request to the pads |
| kbd_tap | output | 8 | Synchronized pin levels for keyboard-interrupt logic |

## Verification
The checker watches these rules on every cycle:
- reset state
- the one-cycle link from a direction write to `pin_oe`
- pull-up exclusion on output bits
- the bit-by-bit makeup of a data read against `pin_out` and `kbd_tap`
- the two-edge synchronizer delay
- zero reads of unmapped offsets
- steadiness of driven bits between latch writes

Some behaviours only the directed scenarios can show, because they depend on what was stored earlier:
- the exact read-back of the direction and pull-up registers
- a latch value stored while its pin was an input and driven later
- unmapped writes leaving every register intact
- the absence of an intermediate level when a pin turns into an output

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    // Register offsets on the port bus; software depends on these values.
    localparam int unsigned OFS_LATCH = 32'h00;
    localparam int unsigned OFS_DIR   = 32'h04;
    localparam int unsigned OFS_PULL  = 32'h0D;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_LATCH = 2'd1,
        SEL_DIR   = 2'd2,
        SEL_PULL  = 2'd3
    } reg_sel_e;

    // Maps a zero-extended bus offset to the register it selects.
    function automatic reg_sel_e decode_offset(input logic [31:0] ofs);
        reg_sel_e sel;
        case (ofs)
            OFS_LATCH: sel = SEL_LATCH;
            OFS_DIR:   sel = SEL_DIR;
            OFS_PULL:  sel = SEL_PULL;
            default:   sel = SEL_NONE;
        endcase
        return sel;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    localparam int LAST = STAGES - 1;

    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain <= '0;
                end else begin
                    chain <= {chain[STAGES-2:0], async_in[b]};
                end
            end
            assign sync_out[b] = chain[LAST];
        end
    endgenerate
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  reg_sel_e         sel,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] latch_q,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] pull_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
            dir_q   <= '0;
            pull_q  <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_LATCH: latch_q <= wdata;
                SEL_DIR:   dir_q   <= wdata;
                SEL_PULL:  pull_q  <= wdata;
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
    import gpio_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  reg_sel_e         sel,
    input  logic [WIDTH-1:0] latch_q,
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] pull_q,
    input  logic [WIDTH-1:0] pin_sync,
    output logic [WIDTH-1:0] pin_oe,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_pu,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] port_view;

    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_pad
            assign pin_oe[b]    = dir_q[b];
            assign pin_out[b]   = dir_q[b] & latch_q[b];
            assign pin_pu[b]    = pull_q[b] & ~dir_q[b];
            assign port_view[b] = dir_q[b] ? latch_q[b] : pin_sync[b];
        end
    endgenerate

    always_comb begin
        case (sel)
            SEL_LATCH: rdata = port_view;
            SEL_DIR:   rdata = dir_q;
            SEL_PULL:  rdata = pull_q;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int WIDTH  = 8,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  pin_oe,
    output logic [WIDTH-1:0]  pin_out,
    output logic [WIDTH-1:0]  pin_pu,
    output logic [WIDTH-1:0]  kbd_tap
);
    localparam int SYNC_STAGES = 2;

    reg_sel_e         sel;
    logic             wr_en;
    logic [WIDTH-1:0] latch_q;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] pull_q;
    logic [WIDTH-1:0] pin_sync;

    assign sel     = decode_offset(32'(bus_addr));
    assign wr_en   = bus_en & bus_we;
    assign kbd_tap = pin_sync;

    gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    gpio_regs #(.WIDTH(WIDTH)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .sel     (sel),
        .wdata   (bus_wdata),
        .latch_q (latch_q),
        .dir_q   (dir_q),
        .pull_q  (pull_q)
    );

    gpio_pad_ctrl #(.WIDTH(WIDTH)) u_pad (
        .sel      (sel),
        .latch_q  (latch_q),
        .dir_q    (dir_q),
        .pull_q   (pull_q),
        .pin_sync (pin_sync),
        .pin_oe   (pin_oe),
        .pin_out  (pin_out),
        .pin_pu   (pin_pu),
        .rdata    (bus_rdata)
    );
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
    import gpio_pkg::*;
#(
    parameter int WIDTH  = 8,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_en,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [WIDTH-1:0]  bus_wdata,
    input logic [WIDTH-1:0]  bus_rdata,
    input logic [WIDTH-1:0]  pin_in,
    input logic [WIDTH-1:0]  pin_oe,
    input logic [WIDTH-1:0]  pin_out,
    input logic [WIDTH-1:0]  pin_pu,
    input logic [WIDTH-1:0]  kbd_tap
);
    logic [1:0] live;
    logic       rd_latch;
    logic       unmapped;
    logic       latch_wr;
    logic       dir_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            live <= '0;
        end else if (live != 2'd3) begin
            live <= live + 2'd1;
        end
    end

    assign rd_latch = (32'(bus_addr) == OFS_LATCH);
    assign unmapped = (32'(bus_addr) != OFS_LATCH) && (32'(bus_addr) != OFS_DIR)
                      && (32'(bus_addr) != OFS_PULL);
    assign latch_wr = bus_en && bus_we && rd_latch;
    assign dir_wr   = bus_en && bus_we && (32'(bus_addr) == OFS_DIR);

    p_reset_state_r1: assert property (@(posedge clk)
        $past(rst) |-> (pin_oe == '0 && pin_out == '0 && pin_pu == '0));

    p_dir_to_oe_r3: assert property (@(posedge clk) disable iff (rst)
        dir_wr |=> (pin_oe == $past(bus_wdata)));

    p_read_mix_r4: assert property (@(posedge clk) disable iff (rst)
        rd_latch |-> ((((bus_rdata ^ kbd_tap) & ~pin_oe) == '0)
                      && (((bus_rdata ^ pin_out) & pin_oe) == '0)));

    p_pullup_excl_r6: assert property (@(posedge clk) disable iff (rst)
        ((pin_pu & pin_oe) == '0));

    p_sync_delay_r8: assert property (@(posedge clk) disable iff (rst)
        (live >= 2'd2) |-> (kbd_tap == $past(pin_in, 2)));

    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (rst)
        unmapped |-> (bus_rdata == '0));

    p_drive_steady_r10: assert property (@(posedge clk) disable iff (rst)
        ((live >= 2'd1) && !$past(latch_wr))
            |-> (((pin_out ^ $past(pin_out)) & pin_oe & $past(pin_oe)) == '0));
endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/gpio_port_bench.sv
module gpio_port_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_en = 1'b0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] pin_oe;
    logic [7:0] pin_out;
    logic [7:0] pin_pu;
    logic [7:0] kbd_tap;

    int n_chk = 0;
    int n_err = 0;
    logic mon_en = 1'b0;
    logic mon_bad = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    gpio_port u_gpio_port (
        .clk       (clk),
        .rst       (rst),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_oe    (pin_oe),
        .pin_out   (pin_out),
        .pin_pu    (pin_pu),
        .kbd_tap   (kbd_tap)
    );

    // Glitch monitor for bit 0: once enabled, the pin may only show level 1.
    always @(negedge clk) begin
        if (mon_en && pin_oe[0] && pin_out[0] !== 1'b1) mon_bad <= 1'b1;
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic set_pins(input logic [7:0] v);
        @(negedge clk);
        pin_in = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] r;
        chk("R1 pin_oe", pin_oe, 8'h00);
        chk("R1 pin_out", pin_out, 8'h00);
        chk("R1 pin_pu", pin_pu, 8'h00);
        bus_read(8'h04, r); chk("R1 dir read", r, 8'h00);
        bus_read(8'h0D, r); chk("R1 pull read", r, 8'h00);
        bus_read(8'h00, r); chk("R1 data read", r, 8'h00);
    endtask

    task automatic t_regs();
        logic [7:0] r;
        bus_write(8'h04, 8'hA5); bus_read(8'h04, r); chk("R2 dir A5", r, 8'hA5);
        bus_write(8'h0D, 8'h3C); bus_read(8'h0D, r); chk("R2 pull 3C", r, 8'h3C);
        bus_write(8'h04, 8'h5A); bus_read(8'h04, r); chk("R2 dir 5A", r, 8'h5A);
        bus_write(8'h04, 8'h00); bus_write(8'h0D, 8'h00);
    endtask

    task automatic t_drive();
        bus_write(8'h00, 8'h5A);
        bus_write(8'h04, 8'hF0);
        chk("R3 pin_oe", pin_oe, 8'hF0);
        chk("R3 pin_out", pin_out, 8'h50);
    endtask

    task automatic t_read_mix();
        logic [7:0] r;
        set_pins(8'h0F);
        bus_read(8'h00, r); chk("R4 mix pins 0F", r, 8'h5F);
        set_pins(8'hF0);
        bus_read(8'h00, r); chk("R4 mix pins F0", r, 8'h50);
    endtask

    task automatic t_latch_input();
        logic [7:0] r;
        bus_write(8'h04, 8'h00);
        set_pins(8'h00);
        bus_write(8'h00, 8'hFF);
        chk("R5 pin_out idle", pin_out, 8'h00);
        chk("R5 pin_oe idle", pin_oe, 8'h00);
        bus_read(8'h00, r); chk("R5 read pins", r, 8'h00);
        bus_write(8'h04, 8'hFF);
        chk("R5 driven later", pin_out, 8'hFF);
        bus_read(8'h00, r); chk("R5 read latch", r, 8'hFF);
    endtask

    task automatic t_pullup();
        bus_write(8'h04, 8'h0F);
        bus_write(8'h0D, 8'hFF);
        chk("R6 pu masked", pin_pu, 8'hF0);
        bus_write(8'h04, 8'h00);
        chk("R6 pu all", pin_pu, 8'hFF);
        bus_write(8'h0D, 8'h00);
    endtask

    task automatic t_tap();
        bus_write(8'h04, 8'hFF);
        set_pins(8'h96);
        chk("R7 tap outputs", kbd_tap, 8'h96);
        bus_write(8'h04, 8'h00);
        set_pins(8'h69);
        chk("R7 tap inputs", kbd_tap, 8'h69);
    endtask

    task automatic t_sync();
        set_pins(8'h00);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = 8'h00;
        pin_in = 8'h81;
        @(negedge clk);
        chk("R8 tap after 1 edge", kbd_tap, 8'h00);
        chk("R8 read after 1 edge", bus_rdata, 8'h00);
        @(negedge clk);
        chk("R8 tap after 2 edges", kbd_tap, 8'h81);
        chk("R8 read after 2 edges", bus_rdata, 8'h81);
        bus_en = 1'b0;
    endtask

    task automatic t_unmapped();
        logic [7:0] r;
        bus_write(8'h00, 8'h77);
        bus_write(8'h04, 8'h3C);
        bus_write(8'h0D, 8'h11);
        bus_write(8'h01, 8'hFF); bus_write(8'h05, 8'hFF);
        bus_write(8'h0C, 8'hFF); bus_write(8'hFF, 8'h00);
        bus_read(8'h01, r); chk("R9 read 01", r, 8'h00);
        bus_read(8'h0C, r); chk("R9 read 0C", r, 8'h00);
        bus_read(8'hFF, r); chk("R9 read FF", r, 8'h00);
        bus_read(8'h04, r); chk("R9 dir kept", r, 8'h3C);
        bus_read(8'h0D, r); chk("R9 pull kept", r, 8'h11);
        chk("R9 latch kept", pin_out, 8'h34);
    endtask

    task automatic t_glitch();
        bus_write(8'h04, 8'h00);
        bus_write(8'h00, 8'h00);
        @(negedge clk);
        mon_en = 1'b1; mon_bad = 1'b0;
        bus_write(8'h00, 8'h01);
        chk("R10 still hi-z", pin_oe, 8'h00);
        bus_write(8'h04, 8'h01);
        chk("R10 oe on", pin_oe, 8'h01);
        chk("R10 level", pin_out, 8'h01);
        repeat (3) @(negedge clk);
        chk("R10 no glitch", {7'd0, mon_bad}, 8'h00);
        mon_en = 1'b0;
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=hung expected=done");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regs();
        t_drive();
        t_read_mix();
        t_latch_input();
        t_pullup();
        t_tap();
        t_sync();
        t_unmapped();
        t_glitch();
        report();
    end
endmodule